// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins behind a simple register bus. Every pin has an output-enable, an output value, a synchronized input sample, and an interrupt detector. The detector can watch for a level or a single edge, and the polarity bit chooses high or rising against low or falling. Detected triggers can be latched in a per-pin status bit. All pins are combined into one summary interrupt line.

Two enable bits act independently of each other. The status-capture enable decides only whether a trigger is recorded in the status bit. The interrupt enable decides only whether the trigger reaches the summary line. A per-pin routing code then decides whether the pin's interrupt goes to the application processor at all.

The bus is single-cycle. A write takes effect at the clock edge where `bus_en` and `bus_wr` are both high. Read data appears combinationally on `bus_rdata` while `bus_en` is high and `bus_wr` is low. Pin n uses these word addresses: control at 0x1000+0x10·n, data at 0x1004+0x10·n, trigger setup at 0x1008+0x10·n, status at 0x100C+0x10·n, and routing at 0x0400+0x04·n. An address outside these windows reads 0, and a write to it changes nothing.

Top module: `pinbank_irq`

## Requirements
- R1: After reset, every output enable, output value, trigger-setup field and status bit is 0, every routing code reads 7, and `summary_irq` is 0.
- R2: The control register holds the output enable in bit 9, which drives `pin_oe[n]`. Data-register bit 1 holds the output value, which drives `pin_out[n]`. The trigger-setup register holds bits [3:0]: bit 0 interrupt enable, bit 1 polarity (1 = high or rising), bit 2 mode (1 = edge, 0 = level), bit 3 status-capture enable. The routing register holds bits [2:0]. All other bits read 0.
- R3: Data-register bit 0 reads the pin input through a two-flop synchronizer. A change driven before clock edge k is readable after edge k+1.
- R4: In edge mode only the edge selected by polarity triggers; the opposite edge has no effect on status or summary. A trigger from an input change before edge k shows in status and summary after edge k+2.
- R5: In level mode the trigger holds while the input sits at the polarity level. A status clear written during that time does not stick. A clear written after the input goes inactive does.
- R6: With status capture disabled, a trigger leaves the status bit at 0 but still raises `summary_irq` when the interrupt is enabled and routed. For an edge this is a one-cycle pulse.
- R7: With the interrupt enable at 0, a trigger still sets status when capture is enabled, but `summary_irq` stays 0. Setting the enable later raises `summary_irq` from the pending status.
- R8: Writing 1 to status bit 0 clears that pin's status. Writing 0 leaves it unchanged.
- R9: If a status clear and a new captured trigger fall in the same cycle, the status bit ends set.
- R10: Only routing code 4 sends a pin's interrupt to `summary_irq`. Any other code, such as 7 (no processor) or 3, suppresses it, while status capture continues.
- R11: `summary_irq` is the OR over all pins. It stays high until every enabled, routed pin has no pending status and no active trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational) |
| pin_in | input | NPINS | Raw pin inputs |
| pin_out | output | NPINS | Output values |
| pin_oe | output | NPINS | Output enables |
| summary_irq | output | 1 | Aggregated interrupt to the application processor |

## Verification
The hardest case to reach is the race between a status clear and a new captured edge in the same cycle. The edge only exists for one cycle, two clock edges after the input moves. The stimulus drives a rising input at a known falling clock edge, waits exactly one more cycle, and then issues the status write, so both arrive at the same register edge. Level-mode re-setting and the one-cycle summary pulse with capture disabled are also timed cycle-exactly against the synchronizer latency.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int          ROUTE_W    = 3;
    localparam logic [2:0]  ROUTE_APP  = 3'd4;
    localparam logic [2:0]  ROUTE_NONE = 3'd7;
    localparam int          OE_BIT     = 9;

    // register select within a pin's 16-byte window
    localparam logic [1:0]  SEL_CTRL   = 2'd0;
    localparam logic [1:0]  SEL_DATA   = 2'd1;
    localparam logic [1:0]  SEL_TRIG   = 2'd2;
    localparam logic [1:0]  SEL_STAT   = 2'd3;

    // trigger setup, bit3..bit0
    typedef struct packed {
        logic raw_en;
        logic edge_mode;
        logic pol_hi;
        logic irq_en;
    } icfg_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] samp,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] old;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = raw;
        st_d.s2  = st_q.s1;
        st_d.old = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign samp = st_q.s2;
    assign prev = st_q.old;
endmodule

// File: rtl/pin_detect.sv
module pin_detect
    import pinbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  samp,
    input  logic  prev,
    input  icfg_t cfg,
    input  logic  clr,
    output logic  trig,
    output logic  status
);
    typedef struct packed {
        logic status;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        if (cfg.edge_mode) trig = cfg.pol_hi ? (samp & ~prev) : (~samp & prev);
        else               trig = (samp == cfg.pol_hi);
        st_d = st_q;
        // a captured trigger outranks a same-cycle clear
        if (trig && cfg.raw_en) st_d.status = 1'b1;
        else if (clr)           st_d.status = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
    import pinbank_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             summary_irq
);
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam logic [AW-13:0] PIN_HI = 1;   // 0x1000 window
    localparam logic [AW-11:0] RT_HI  = 1;   // 0x0400 window

    typedef struct packed {
        logic [NPINS-1:0]              oe;
        logic [NPINS-1:0]              dout;
        icfg_t [NPINS-1:0]             icfg;
        logic [NPINS-1:0][ROUTE_W-1:0] route;
        logic                          summary;
    } bank_t;

    bank_t st_d, st_q;

    logic [NPINS-1:0] samp_w, prev_w, trig_w, status_w, clr_w;
    logic             pin_hit, rt_hit;
    logic [IDX_W-1:0] pin_idx, rt_idx;
    logic [1:0]       sel;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[DW-1:OE_BIT+1], bus_wdata[OE_BIT-1:4], bus_addr[1:0]};

    pin_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pin_in),
        .samp (samp_w),
        .prev (prev_w)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pin_detect u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .samp  (samp_w[g]),
            .prev  (prev_w[g]),
            .cfg   (st_q.icfg[g]),
            .clr   (clr_w[g]),
            .trig  (trig_w[g]),
            .status(status_w[g])
        );
    end

    always_comb begin
        logic any;
        st_d      = st_q;
        clr_w     = '0;
        bus_rdata = '0;
        sel       = bus_addr[3:2];
        pin_idx   = bus_addr[4 +: IDX_W];
        rt_idx    = bus_addr[2 +: IDX_W];
        pin_hit   = bus_en && (bus_addr[AW-1:12] == PIN_HI) && (int'(bus_addr[11:4]) < NPINS);
        rt_hit    = bus_en && (bus_addr[AW-1:10] == RT_HI)  && (int'(bus_addr[9:2])  < NPINS);

        if (pin_hit) begin
            if (bus_wr) begin
                case (sel)
                    SEL_CTRL: st_d.oe[pin_idx]   = bus_wdata[OE_BIT];
                    SEL_DATA: st_d.dout[pin_idx] = bus_wdata[1];
                    SEL_TRIG: st_d.icfg[pin_idx] = icfg_t'(bus_wdata[3:0]);
                    default:  clr_w[pin_idx]     = bus_wdata[0];
                endcase
            end else begin
                case (sel)
                    SEL_CTRL: bus_rdata[OE_BIT] = st_q.oe[pin_idx];
                    SEL_DATA: bus_rdata[1:0]    = {st_q.dout[pin_idx], samp_w[pin_idx]};
                    SEL_TRIG: bus_rdata[3:0]    = st_q.icfg[pin_idx];
                    default:  bus_rdata[0]      = status_w[pin_idx];
                endcase
            end
        end else if (rt_hit) begin
            if (bus_wr) st_d.route[rt_idx] = bus_wdata[ROUTE_W-1:0];
            else        bus_rdata[ROUTE_W-1:0] = st_q.route[rt_idx];
        end

        any = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            any = any | (st_q.icfg[i].irq_en && (st_q.route[i] == ROUTE_APP)
                         && (trig_w[i] || status_w[i]));
        end
        st_d.summary = any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.route <= {NPINS{ROUTE_NONE}};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out     = st_q.dout;
    assign pin_oe      = st_q.oe;
    assign summary_irq = st_q.summary;
endmodule

// File: rtl/pinbank_irq_chk.sv
module pinbank_irq_chk #(
    parameter int NPINS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 summary_irq,
    input logic [NPINS-1:0]     status,
    input logic [NPINS-1:0]     clr,
    input logic [4*NPINS-1:0]   icfg_flat,
    input logic [3*NPINS-1:0]   route_flat
);
    logic [NPINS-1:0] armed;
    always_comb begin
        for (int i = 0; i < NPINS; i++)
            armed[i] = icfg_flat[4*i] && (route_flat[3*i +: 3] == 3'd4);
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        // R6: status only rises when capture was enabled
        assert_status_needs_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[g]) |-> $past(icfg_flat[4*g+3]));
        // R8: status only falls through a write-1 clear
        assert_status_fall_by_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status[g]) |-> $past(clr[g]));
    end

    // R10: summary requires some enabled pin routed to the application processor
    assert_summary_needs_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        summary_irq |-> $past(|armed));

    // R11: pending status on an armed pin keeps summary high next cycle
    assert_summary_follows_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(armed & status)) |=> summary_irq);

    // R1: no status pending right as reset releases
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == '0) && !summary_irq);
endmodule

bind pinbank_irq pinbank_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .summary_irq(summary_irq),
    .status     (status_w),
    .clr        (clr_w),
    .icfg_flat  (st_q.icfg),
    .route_flat (st_q.route)
);

// File: tb/test_pinbank_irq.sv
`timescale 1ns/1ps
module test_pinbank_irq;
    localparam int NPINS = 8;
    localparam int AW    = 16;
    localparam int DW    = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_en = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [DW-1:0]    bus_wdata = '0;
    logic [DW-1:0]    bus_rdata;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] pin_out, pin_oe;
    logic             summary_irq;

    int nchk = 0, nerr = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        int          kind;   // 0 rdata, 1 summary, 2 pin_out, 3 pin_oe
        logic [31:0] exp;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    pinbank_irq #(.NPINS(NPINS), .AW(AW), .DW(DW)) i_pinbank_irq (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .summary_irq(summary_irq)
    );

    function automatic logic [15:0] a_ctl(int n);  return 16'(32'h1000 + 16*n); endfunction
    function automatic logic [15:0] a_dat(int n);  return 16'(32'h1004 + 16*n); endfunction
    function automatic logic [15:0] a_trg(int n);  return 16'(32'h1008 + 16*n); endfunction
    function automatic logic [15:0] a_sts(int n);  return 16'(32'h100C + 16*n); endfunction
    function automatic logic [15:0] a_rt(int n);   return 16'(32'h0400 + 4*n);  endfunction

    // monitor: pops expected items and compares against the live outputs
    initial begin
        forever begin
            item_t it;
            logic [31:0] got;
            wait (q.size() > 0);
            it = q.pop_front();
            case (it.kind)
                0:       got = bus_rdata;
                1:       got = {31'b0, summary_irq};
                2:       got = 32'(pin_out);
                default: got = 32'(pin_oe);
            endcase
            nchk++;
            if (got !== it.exp) begin
                nerr++;
                $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic push(string tag, int kind, logic [31:0] exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic exp_rd(logic [15:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_addr = a;
        #2;
        push(tag, 0, e);
        bus_en = 0;
    endtask

    task automatic exp_out(int kind, logic [31:0] e, string tag);
        @(negedge clk);
        #2;
        push(tag, kind, e);
    endtask

    task automatic set_pin(int n, logic v);
        @(negedge clk);
        pin_in[n] = v;
    endtask

    initial begin
        #800000;
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        // R1 reset state
        exp_rd(a_rt(0), 32'd7, "R1 route 0 reset");
        exp_rd(a_rt(7), 32'd7, "R1 route 7 reset");
        exp_rd(a_trg(3), 32'd0, "R1 trigger setup reset");
        exp_rd(a_ctl(0), 32'd0, "R1 control reset");
        exp_rd(a_sts(0), 32'd0, "R1 status reset");
        exp_out(1, 0, "R1 summary reset");
        exp_out(3, 0, "R1 oe reset");

        // R2 register map
        wr(a_ctl(2), 32'hFFFF_FFFF);
        exp_out(3, 32'h4, "R2 oe bit drives pin_oe");
        exp_rd(a_ctl(2), 32'h200, "R2 control only bit 9");
        wr(a_dat(2), 32'h2);
        exp_out(2, 32'h4, "R2 output value drives pin_out");
        exp_rd(a_dat(2), 32'h2, "R2 data readback");
        wr(a_trg(5), 32'hFFFF_FFFF);
        exp_rd(a_trg(5), 32'hF, "R2 trigger setup readback");
        wr(a_trg(5), 0);
        wr(a_rt(5), 32'h4);
        exp_rd(a_rt(5), 32'h4, "R2 route readback");
        wr(a_rt(5), 32'h7);

        // R3 synchronizer latency
        set_pin(1, 1);
        exp_rd(a_dat(1), 32'h0, "R3 input not yet visible");
        exp_rd(a_dat(1), 32'h1, "R3 input visible after two flops");

        // R4 rising edge on pin 0
        wr(a_rt(0), 4);
        wr(a_trg(0), 32'hF);
        set_pin(0, 1); idle(2);
        exp_out(1, 1, "R4 rising edge raises summary");
        exp_rd(a_sts(0), 1, "R4 rising edge sets status");
        wr(a_sts(0), 1);
        exp_rd(a_sts(0), 0, "R8 write-1 clears status");
        exp_out(1, 0, "R11 summary drops after clear");
        set_pin(0, 0); idle(2);
        exp_out(1, 0, "R4 opposite edge no summary");
        exp_rd(a_sts(0), 0, "R4 opposite edge no status");
        // falling polarity
        wr(a_trg(0), 32'hD);
        set_pin(0, 1); idle(2);
        exp_out(1, 0, "R4 rising ignored in falling mode");
        set_pin(0, 0); idle(2);
        exp_out(1, 1, "R4 falling edge raises summary");
        exp_rd(a_sts(0), 1, "R4 falling edge sets status");
        wr(a_sts(0), 1);

        // R6 capture disabled: pulse only
        wr(a_trg(0), 32'h7);
        set_pin(0, 1); idle(2);
        exp_out(1, 1, "R6 summary pulse without capture");
        exp_out(1, 0, "R6 pulse lasts one cycle");
        exp_rd(a_sts(0), 0, "R6 status stays clear");

        // R7 interrupt disabled
        wr(a_trg(0), 32'hE);
        set_pin(0, 0); idle(3);
        set_pin(0, 1); idle(2);
        exp_out(1, 0, "R7 no summary with irq disabled");
        exp_rd(a_sts(0), 1, "R7 status still captured");
        wr(a_trg(0), 32'hF);
        exp_out(1, 1, "R7 enabling raises summary from pending");
        wr(a_sts(0), 1);
        exp_out(1, 0, "R7 summary drops after clear");

        // R10 routing
        wr(a_rt(0), 7);
        set_pin(0, 0); idle(3);
        set_pin(0, 1); idle(2);
        exp_out(1, 0, "R10 route 7 suppresses");
        exp_rd(a_sts(0), 1, "R10 status captured while unrouted");
        wr(a_rt(0), 4);
        exp_out(1, 1, "R10 route 4 delivers");
        wr(a_rt(0), 3);
        exp_out(1, 0, "R10 route 3 suppresses");
        wr(a_rt(0), 4);
        wr(a_sts(0), 1);
        exp_out(1, 0, "R10 cleared");

        // R5 level mode
        wr(a_rt(3), 4);
        wr(a_trg(3), 32'hB);
        set_pin(3, 1); idle(2);
        exp_out(1, 1, "R5 level high raises summary");
        wr(a_sts(3), 1);
        exp_rd(a_sts(3), 1, "R5 clear does not stick while active");
        set_pin(3, 0); idle(2);
        wr(a_sts(3), 1);
        exp_rd(a_sts(3), 0, "R5 clear sticks once inactive");
        exp_out(1, 0, "R5 summary low after level ends");
        wr(a_trg(3), 32'h9);
        idle(2);
        exp_rd(a_sts(3), 1, "R5 level low captured");
        wr(a_trg(3), 0);
        wr(a_sts(3), 1);
        exp_rd(a_sts(3), 0, "R5 level low cleared");

        // R11 two pins, R8 write 0
        wr(a_rt(4), 4); wr(a_trg(4), 32'hF);
        wr(a_rt(6), 4); wr(a_trg(6), 32'hF);
        set_pin(4, 1); set_pin(6, 1); idle(3);
        exp_out(1, 1, "R11 two pins pending");
        wr(a_sts(6), 0);
        exp_rd(a_sts(6), 1, "R8 write 0 leaves status");
        wr(a_sts(4), 1);
        exp_out(1, 1, "R11 summary held by other pin");
        wr(a_sts(6), 1);
        exp_out(1, 0, "R11 summary low when none pending");

        // R9 clear and trigger in the same cycle
        set_pin(4, 0); idle(3);
        set_pin(4, 1); idle(1);
        wr(a_sts(4), 1);
        exp_rd(a_sts(4), 1, "R9 trigger wins over clear");
        wr(a_sts(4), 1);
        exp_rd(a_sts(4), 0, "R9 later clear works");

        idle(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule